// File: doc/BRIEF.md
# Extended-Precision Exponent and Significand Splitter

The block takes one 80-bit extended-precision operand and returns two 80-bit results. The first is the operand's true unbiased exponent, converted to an extended-precision number. The second is the operand's significand with its exponent field rebiased to 3FFFh, so its magnitude lies in [1,2). A caller that keeps an operand stack writes the exponent result over the old slot and pushes the significand result. Updating the stack pointer is not part of this block.

Denormal operands are normalized before the split. The mantissa is shifted left by its leading-zero count, and the effective exponent is lowered by the same amount. The signed integer exponent is turned into floating point by taking its magnitude, counting the magnitude's leading zeros and shifting left by that count. Zero, infinity, NaN and empty operands produce fixed result pairs and the matching exception flags. The block is pipelined over three register stages and accepts a new start on every cycle.

Top module: `expsig_split`

## Requirements
- R1: Word layout: bit 79 is the sign, bits 78:64 hold the exponent biased by 16383, and bits 63:0 hold the mantissa with an explicit integer bit at 63. For an operand whose exponent field is in 1..7FFEh, the significand result is {operand sign, 3FFFh, operand mantissa}, and no flag is raised.
- R2: For an operand whose exponent field is in 1..7FFEh, the exponent result is the integer (field − 16383) as a normalized extended value: the sign is set for negative values, bit 63 is set, and the value is exact. An integer of 0 gives the all-zero word (+0).
- R3: A denormal operand has exponent field 0 and a non-zero mantissa with n leading zeros. The significand result is {sign, 3FFFh, mantissa << n}, the exponent result is −16382 − n, and the denormal flag is raised.
- R4: A zero operand (field 0, mantissa 0) gives an exponent result of −infinity {1, 7FFFh, 8000_0000_0000_0000h} and a significand result of {operand sign, 0, 0}, and raises zero-divide.
- R5: An infinity operand (field 7FFFh, mantissa bits 62:0 all zero) gives +infinity {0, 7FFFh, 8000_0000_0000_0000h} as the exponent result and {operand sign, 7FFFh, 8000_0000_0000_0000h} as the significand result, and raises no flag.
- R6: A NaN operand (field 7FFFh, mantissa bits 62:0 not all zero) raises invalid. Both results become the indefinite value {1, 7FFFh, C000_0000_0000_0000h}.
- R7: When the empty tag is high, the operand bits are ignored. The block raises invalid and stack-fault, and both results are the indefinite value.
- R8: The start strobe is sampled on a rising edge. done is high for exactly the cycle that follows the third rising edge, counting the sampling edge as the first. Results and flags update at that edge and hold until the next done.
- R9: While reset is active and after it is released, done, all four flags and both results are zero until the first result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a split of the presented operand |
| op_in | input | 80 | Extended-precision operand |
| op_empty | input | 1 | Operand slot holds no value |
| done | output | 1 | One-cycle result strobe |
| exp_out | output | 80 | Unbiased exponent as an extended value |
| sig_out | output | 80 | Significand rebiased to exponent 3FFFh |
| flag_inv | output | 1 | Invalid operation |
| flag_sf | output | 1 | Stack fault |
| flag_den | output | 1 | Denormal operand |
| flag_zd | output | 1 | Zero divide |

## Verification
The bench aims at the exponent boundaries. An operand in [1,2) must give +0, not a word with a stray bias. The largest field must give +16383, and the smallest denormal must give −16445; a design that sizes the signed exponent one bit too narrow wraps the sign at these points. Denormals with every possible leading-zero count are drawn, so an off-by-one in the normalizing shift shows up as a significand without its integer bit or an exponent that is one too high. Empty operands carry random bits, so a design that decodes the operand before checking the tag reports infinity or a number instead of the indefinite pair with stack-fault.

// File: rtl/expsig_split.sv
module expsig_split #(
  parameter int EW = 15,
  parameter int MW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [EW+MW:0]    op_in,
  input  logic              op_empty,
  output logic              done,
  output logic [EW+MW:0]    exp_out,
  output logic [EW+MW:0]    sig_out,
  output logic              flag_inv,
  output logic              flag_sf,
  output logic              flag_den,
  output logic              flag_zd
);
  localparam int W    = 1 + EW + MW;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int XEW  = EW + 2;
  localparam int LZW  = $clog2(MW) + 1;
  localparam logic [EW-1:0] EMAX = '1;
  localparam logic [MW-1:0] TOP  = {1'b1, {(MW-1){1'b0}}};
  localparam logic [W-1:0]  INDEF = {1'b1, EMAX, 2'b11, {(MW-2){1'b0}}};

  typedef enum logic [1:0] {K_NUM, K_ZERO, K_INF, K_INV} kind_t;

  function automatic logic [LZW-1:0] lead0(input logic [MW-1:0] v);
    logic seen;
    lead0 = '0;
    seen  = 1'b0;
    for (int i = MW - 1; i >= 0; i--) begin
      if (v[i]) seen = 1'b1;
      else if (!seen) lead0 = lead0 + 1'b1;
    end
  endfunction

  // stage A: capture
  logic           v0, emp0;
  logic [W-1:0]   op0;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin v0 <= 1'b0; emp0 <= 1'b0; op0 <= '0; end
    else begin
      v0 <= start;
      if (start) begin op0 <= op_in; emp0 <= op_empty; end
    end

  // stage B: classify and normalize
  wire [EW-1:0] e0   = op0[W-2:MW];
  wire [MW-1:0] m0   = op0[MW-1:0];
  wire          emx  = &e0;
  wire          ez   = (e0 == '0);
  wire          fz   = (m0[MW-2:0] == '0);
  wire          den  = !emp0 && ez && (m0 != '0);
  wire [LZW-1:0] lz  = lead0(m0);
  kind_t kind_c;
  always_comb
    if (emp0 || (emx && !fz)) kind_c = K_INV;
    else if (emx)             kind_c = K_INF;
    else if (ez && m0 == '0)  kind_c = K_ZERO;
    else                      kind_c = K_NUM;
  wire [XEW-1:0] xe_c = den ? XEW'(1) - XEW'(BIAS) - XEW'(lz)
                            : XEW'(e0) - XEW'(BIAS);
  wire [MW-1:0]  mn_c = den ? m0 << lz : m0;

  logic          v1, s1;
  kind_t         kind1;
  logic [XEW-1:0] xe1;
  logic [MW-1:0] mn1;
  logic [3:0]    fl1;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0; s1 <= 1'b0; kind1 <= K_NUM; xe1 <= '0; mn1 <= '0; fl1 <= '0;
    end else begin
      v1 <= v0;
      if (v0) begin
        s1 <= op0[W-1]; kind1 <= kind_c; xe1 <= xe_c; mn1 <= mn_c;
        fl1 <= {kind_c == K_INV, emp0, den, kind_c == K_ZERO};
      end
    end

  // stage C: integer exponent to float
  wire            neg  = xe1[XEW-1];
  wire [XEW-1:0]  mag  = neg ? -xe1 : xe1;
  wire [MW-1:0]   mg   = {mag, {(MW-XEW){1'b0}}};
  wire [LZW-1:0]  lz2  = lead0(mg);
  wire [EW-1:0]   fexp = EW'(BIAS + XEW - 1) - EW'(lz2);
  logic [W-1:0] xw, sw;
  always_comb
    case (kind1)
      K_ZERO:  begin xw = {1'b1, EMAX, TOP}; sw = {s1, {(W-1){1'b0}}}; end
      K_INF:   begin xw = {1'b0, EMAX, TOP}; sw = {s1, EMAX, TOP}; end
      K_INV:   begin xw = INDEF; sw = INDEF; end
      default: begin
        xw = (mag == '0) ? '0 : {neg, fexp, mg << lz2};
        sw = {s1, EW'(BIAS), mn1};
      end
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done <= 1'b0; exp_out <= '0; sig_out <= '0;
      {flag_inv, flag_sf, flag_den, flag_zd} <= '0;
    end else begin
      done <= v1;
      if (v1) begin
        exp_out <= xw; sig_out <= sw;
        {flag_inv, flag_sf, flag_den, flag_zd} <= fl1;
      end
    end

  // R8
  done_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 3));
  // R6
  inv_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && flag_inv |-> exp_out == INDEF && sig_out == INDEF);
  // R7
  sf_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_sf |-> flag_inv);
  // R4
  zd_neginf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && flag_zd |-> exp_out == {1'b1, EMAX, TOP} && sig_out[W-2:0] == '0);
  // R3
  den_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && flag_den |-> sig_out[MW-1] && sig_out[W-2:MW] == EW'(BIAS) && exp_out[W-1]);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(exp_out) && $stable(sig_out));
endmodule

// File: tb/expsig_split_bench.sv
module expsig_split_bench;
  logic clk = 0, rst_n = 0, start = 0, op_empty = 0;
  logic [79:0] op_in = '0;
  logic done, flag_inv, flag_sf, flag_den, flag_zd;
  logic [79:0] exp_out, sig_out;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  expsig_split u_expsig_split (.clk, .rst_n, .start, .op_in, .op_empty, .done,
    .exp_out, .sig_out, .flag_inv, .flag_sf, .flag_den, .flag_zd);

  localparam logic [79:0] INDEF  = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};
  localparam logic [79:0] PINF   = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] NINF   = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000};

  function automatic logic [79:0] to_fp(input int v);
    logic [63:0] m; int ex; bit s;
    if (v == 0) return '0;
    s = v < 0;
    m = 64'(s ? -v : v);
    ex = 16383 + 63;
    while (!m[63]) begin m = m << 1; ex = ex - 1; end
    return {s, 15'(ex), m};
  endfunction

  task automatic model(input logic [79:0] op, input bit emp, output logic [79:0] xe,
                       output logic [79:0] sg, output logic [3:0] fl, output string rq);
    logic [14:0] e; logic [63:0] m; int n;
    e = op[78:64]; m = op[63:0];
    if (emp) begin xe = INDEF; sg = INDEF; fl = 4'b1100; rq = "R7"; end
    else if (e == 15'h7FFF && m[62:0] != 0) begin xe = INDEF; sg = INDEF; fl = 4'b1000; rq = "R6"; end
    else if (e == 15'h7FFF) begin xe = PINF; sg = {op[79], 15'h7FFF, 64'h8000_0000_0000_0000}; fl = 0; rq = "R5"; end
    else if (e == 0 && m == 0) begin xe = NINF; sg = {op[79], 79'd0}; fl = 4'b0001; rq = "R4"; end
    else if (e == 0) begin
      n = 0;
      while (!m[63]) begin m = m << 1; n++; end
      xe = to_fp(-16382 - n); sg = {op[79], 15'h3FFF, m}; fl = 4'b0010; rq = "R3";
    end else begin
      xe = to_fp(int'(e) - 16383); sg = {op[79], 15'h3FFF, m}; fl = 0; rq = "R1/R2";
    end
  endtask

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [163:0] act, input logic [163:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic run(input logic [79:0] op, input bit emp);
    logic [79:0] xe, sg; logic [3:0] fl; string rq;
    logic [163:0] act, exp;
    model(op, emp, xe, sg, fl, rq);
    @(negedge clk); start = 1; op_in = op; op_empty = emp;
    @(negedge clk); start = 0; op_in = {$urandom, $urandom, $urandom}; op_empty = $urandom;
    @(posedge clk); @(posedge clk); #1;
    act = {exp_out, sig_out, flag_inv, flag_sf, flag_den, flag_zd};
    exp = {xe, sg, fl};
    check(done === 1'b1, "R8", "done after third edge", 164'(done), 164'd1);
    check(act === exp, rq, "results", act, exp);
    @(posedge clk); #1;
    check(done === 1'b0 && exp_out === xe && sig_out === sg, "R8", "one-cycle done, held results",
          {done, exp_out, sig_out, 3'b0}, {1'b0, xe, sg, 3'b0});
  endtask

  initial begin
    logic [63:0] m;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check({done, flag_inv, flag_sf, flag_den, flag_zd, exp_out, sig_out} === '0, "R9", "reset state",
          164'({done, flag_inv, flag_sf, flag_den, flag_zd, exp_out, sig_out}), 164'd0);
    rst_n = 1;
    @(posedge clk); #1;
    check(done === 1'b0 && exp_out === '0, "R9", "idle after reset", 164'(exp_out), 164'd0);
    // R2 directed boundaries
    run({1'b0, 15'h3FFF, 64'h8000_0000_0000_0000}, 0);
    run({1'b1, 15'h3FFF, 64'hC000_0000_0000_0001}, 0);
    run({1'b0, 15'h4000, 64'h8000_0000_0000_0000}, 0);
    run({1'b0, 15'h3FFE, 64'h8000_0000_0000_0000}, 0);
    run({1'b0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF}, 0);
    run({1'b1, 15'h0001, 64'h8000_0000_0000_0000}, 0);
    // R3 extremes
    run({1'b0, 15'h0, 64'h1}, 0);
    run({1'b1, 15'h0, 64'h4000_0000_0000_0000}, 0);
    // R4, R5, R6, R7
    run({1'b0, 79'd0}, 0);
    run({1'b1, 79'd0}, 0);
    run(PINF, 0);
    run(NINF, 0);
    run({1'b0, 15'h7FFF, 64'h8000_0000_0000_0001}, 0);
    run({1'b1, 15'h3FFF, 64'h8000_0000_0000_0000}, 1);
    run(PINF, 1);
    for (int i = 0; i < 400; i++) begin
      int r; logic [79:0] op; bit s;
      r = $urandom % 16; s = $urandom;
      m = {$urandom, $urandom};
      case (r)
        0: op = {s, 79'd0};
        1: op = {s, 15'h7FFF, 64'h8000_0000_0000_0000};
        2: op = {s, 15'h7FFF, m[63], m[62:0] | 63'd1};
        3: op = {s, 15'(1 + $urandom % 32766), 1'b1, m[62:0]};
        4, 5: begin
          m = m >> (1 + $urandom % 63);
          if (m == 0) m = 64'd1;
          op = {s, 15'd0, m};
        end
        default: op = {s, 15'(1 + $urandom % 32766), 1'b1, m[62:0]};
      endcase
      run(op, r == 3);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule